// File: doc/BRIEF.md
# Pseudo-static RAM single-write sequencer

This block turns one request from a valid/ready interface into a single asynchronous write cycle on an external pseudo-static RAM. The RAM has a 22-bit address bus, a 16-bit data bus and two active-low byte-lane enables. Each request carries an address, a data word and a 2-bit lane mask. The block drives the chip select, write enable, read (output) enable, lane enables, address-valid strobe and configuration-select pins. It also drives a data word together with a drive-enable for the external tristate buffer. When the cycle, including any padding, is over, it pulses a done flag.

Every timing quantity is a count of clock cycles, taken from configuration inputs while reset is high. There are six: address setup, minimum write-pulse width, chip-select-to-end time, write recovery, data hold and minimum total cycle. The write interval is the span in which chip select, write enable and at least one selected lane are all low. The block always closes the interval by raising write enable first, so write recovery always applies.

Back-pressure: `req_ready` is high only while the sequencer is idle. A request is taken on a rising clock edge with `req_valid` and `req_ready` both high. While `req_ready` is low, the request fields and `req_valid` are not looked at. The done pulse comes in the first cycle in which `req_ready` is high again, so a new request can be taken in that same cycle.

Top module: `psram_wr_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip select, write enable and both lane enables are high, the data drive-enable is low, `wr_done` is low and `req_ready` is high.
- R2: The configuration-select pin is held low, the read-enable pin is held high and the address-valid strobe is held low at all times.
- R3: A request is taken only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle until the done cycle. Changes to the request inputs while `req_ready` is low have no effect on the pins.
- R4: Call the cycle after acceptance cycle 1. Chip select falls in cycle 1 and write enable falls in cycle S+1, where S is the setup count, or 1 when that count is 0.
- R5: Write enable stays low for exactly P cycles. P is the largest of the pulse-width count, the chip-select-to-end count minus S (floored at 0), and 1.
- R6: Mask bit 1 selects the upper lane (`ram_lane_n[1]`) and bit 0 the lower lane (`ram_lane_n[0]`). A selected lane goes low and high in the same cycles as chip select. Mask 00 leaves chip select, write enable and the drive-enable inactive for the whole cycle, but the cycle still runs its full length.
- R7: Write enable rises first. Chip select and the selected lanes stay low for exactly one more cycle and then rise together.
- R8: The drive-enable is high, with the request data on `ram_dq_out`, from the cycle write enable falls until the data-hold count of cycles after it rises. A hold count of 0 drops the drive-enable in the cycle write enable rises.
- R9: The address bus shows the accepted address from cycle 1 until the next acceptance. This holds it for A = max(recovery count, hold count, 1) cycles after write enable rises, and longer.
- R10: The cycle lasts L = max(S+P+A, minimum-cycle count) cycles. `wr_done` is high for exactly cycle L+1, which is also the first cycle with `req_ready` high.
- R11: The timing counts are captured only while reset is high. Changing the configuration inputs afterwards does not alter the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the timing counts |
| cfg_setup | input | 8 | Address setup count |
| cfg_pulse | input | 8 | Minimum write-pulse count |
| cfg_sel_end | input | 8 | Minimum count from chip-select fall to end of write |
| cfg_recover | input | 8 | Write recovery count |
| cfg_hold | input | 8 | Data-hold count after write enable rises |
| cfg_cycle | input | 8 | Minimum total cycle count |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 22 | Word address |
| req_data | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 1 upper, bit 0 lower |
| wr_done | output | 1 | One-cycle pulse at cycle completion |
| ram_addr | output | 22 | RAM address bus |
| ram_dq_out | output | 16 | Data toward the RAM data bus |
| ram_dq_oe | output | 1 | Drive-enable for the data tristate buffer |
| ram_sel_n | output | 1 | Chip select, active low |
| ram_wr_n | output | 1 | Write enable, active low |
| ram_rd_n | output | 1 | Read (output) enable, active low, held high |
| ram_lane_n | output | 2 | Lane enables, active low, bit 1 upper |
| ram_strobe_n | output | 1 | Address-valid strobe, held low |
| ram_cfg_sel | output | 1 | Configuration-register select, held low |

## Verification
The hardest cases to reach are those where one timing count overrides another. Examples are a chip-select-to-end count that stretches the write pulse past its own minimum, a hold count longer than recovery, and a minimum-cycle count that forces padding after the post-write phase. Each of these needs a fresh reset, because the counts are read only then. The bench therefore resets several times, first with directed count sets that make each of these cases win and then with random sets. Under each set it runs transactions with all four mask values. While each cycle is busy it scrambles the request inputs, so that a request which should be ignored would show up on the address or data pins.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;

  // Phases of one write cycle
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // waiting for a request
    ST_SETUP = 3'd1,  // address and select out, write enable high
    ST_PULSE = 3'd2,  // write enable low, data driven
    ST_POST  = 3'd3,  // write enable high, hold/recovery
    ST_PAD   = 3'd4   // padding up to the minimum cycle
  } seq_state_t;

endpackage

// File: rtl/psram_wr_timing.sv
module psram_wr_timing #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_pulse,
  input  logic [CNT_W-1:0] cfg_sel_end,
  input  logic [CNT_W-1:0] cfg_recover,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic [CNT_W-1:0] cfg_cycle,
  output logic [CNT_W-1:0] setup_len,
  output logic [CNT_W-1:0] pulse_len,
  output logic [CNT_W-1:0] post_len,
  output logic [CNT_W-1:0] hold_len,
  output logic [CNT_W-1:0] cycle_min
);

  logic [CNT_W-1:0] setup_q, pulse_q, sel_end_q, recover_q, hold_q, cycle_q;
  logic [CNT_W-1:0] sel_rest;

  // Counts are sampled only while reset is high
  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q   <= cfg_setup;
      pulse_q   <= cfg_pulse;
      sel_end_q <= cfg_sel_end;
      recover_q <= cfg_recover;
      hold_q    <= cfg_hold;
      cycle_q   <= cfg_cycle;
    end
  end

  always_comb begin
    setup_len = (setup_q == '0) ? CNT_W'(1) : setup_q;
    sel_rest  = (sel_end_q > setup_len) ? (sel_end_q - setup_len) : '0;
    pulse_len = (pulse_q > sel_rest) ? pulse_q : sel_rest;
    if (pulse_len == '0) pulse_len = CNT_W'(1);
    post_len  = (recover_q > hold_q) ? recover_q : hold_q;
    if (post_len == '0) post_len = CNT_W'(1);
    hold_len  = hold_q;
    cycle_min = cycle_q;
  end

endmodule

// File: rtl/psram_wr_fsm.sv
module psram_wr_fsm
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int LANES = DATA_W / 8,
  localparam int TOT_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LANES-1:0]  req_be,
  input  logic [CNT_W-1:0]  setup_len,
  input  logic [CNT_W-1:0]  pulse_len,
  input  logic [CNT_W-1:0]  post_len,
  input  logic [CNT_W-1:0]  cycle_min,
  output seq_state_t        state,
  output logic [CNT_W-1:0]  phase,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [LANES-1:0]  be_q,
  output logic              done
);

  seq_state_t       state_q;
  logic [CNT_W-1:0] phase_q;
  logic [TOT_W-1:0] tot_q;     // index of the current cycle, 1 after accept
  logic             done_q;
  logic             cycle_met;

  assign cycle_met = (tot_q >= TOT_W'(cycle_min));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      tot_q   <= '0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            data_q  <= req_data;
            be_q    <= req_be;
            state_q <= ST_SETUP;
            phase_q <= '0;
            tot_q   <= TOT_W'(1);
          end
        end
        ST_SETUP: begin
          tot_q <= tot_q + TOT_W'(1);
          if (phase_q == setup_len - CNT_W'(1)) begin
            state_q <= ST_PULSE;
            phase_q <= '0;
          end else begin
            phase_q <= phase_q + CNT_W'(1);
          end
        end
        ST_PULSE: begin
          tot_q <= tot_q + TOT_W'(1);
          if (phase_q == pulse_len - CNT_W'(1)) begin
            state_q <= ST_POST;
            phase_q <= '0;
          end else begin
            phase_q <= phase_q + CNT_W'(1);
          end
        end
        ST_POST: begin
          tot_q <= tot_q + TOT_W'(1);
          if (phase_q == post_len - CNT_W'(1)) begin
            phase_q <= '0;
            if (cycle_met) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_PAD;
            end
          end else begin
            phase_q <= phase_q + CNT_W'(1);
          end
        end
        ST_PAD: begin
          tot_q <= tot_q + TOT_W'(1);
          if (cycle_met) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign state     = state_q;
  assign phase     = phase_q;
  assign done      = done_q;

endmodule

// File: rtl/psram_wr_pins.sv
module psram_wr_pins
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int LANES = DATA_W / 8
) (
  input  seq_state_t        state,
  input  logic [CNT_W-1:0]  phase,
  input  logic [CNT_W-1:0]  hold_len,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic [LANES-1:0]  be_q,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  output logic              ram_sel_n,
  output logic              ram_wr_n,
  output logic              ram_rd_n,
  output logic [LANES-1:0]  ram_lane_n,
  output logic              ram_strobe_n,
  output logic              ram_cfg_sel
);

  logic active;
  logic sel;
  logic pulse;
  logic post_first;

  assign active     = |be_q;
  assign pulse      = (state == ST_PULSE);
  assign post_first = (state == ST_POST) && (phase == '0);
  assign sel        = active && ((state == ST_SETUP) || pulse || post_first);

  assign ram_sel_n  = ~sel;
  assign ram_wr_n   = ~(active && pulse);
  assign ram_dq_oe  = active && (pulse || ((state == ST_POST) && (phase < hold_len)));

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign ram_lane_n[g] = ~(sel && be_q[g]);
    end
  endgenerate

  assign ram_addr     = addr_q;
  assign ram_dq_out   = data_q;
  assign ram_rd_n     = 1'b1;
  assign ram_strobe_n = 1'b0;
  assign ram_cfg_sel  = 1'b0;

endmodule

// File: rtl/psram_wr_seq.sv
module psram_wr_seq
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_pulse,
  input  logic [CNT_W-1:0]  cfg_sel_end,
  input  logic [CNT_W-1:0]  cfg_recover,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [CNT_W-1:0]  cfg_cycle,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LANES-1:0]  req_be,
  output logic              wr_done,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  output logic              ram_sel_n,
  output logic              ram_wr_n,
  output logic              ram_rd_n,
  output logic [LANES-1:0]  ram_lane_n,
  output logic              ram_strobe_n,
  output logic              ram_cfg_sel
);

  logic [CNT_W-1:0]  setup_len, pulse_len, post_len, hold_len, cycle_min;
  seq_state_t        state;
  logic [CNT_W-1:0]  phase;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  be_q;

  psram_wr_timing #(.CNT_W(CNT_W)) timing_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_setup  (cfg_setup),
    .cfg_pulse  (cfg_pulse),
    .cfg_sel_end(cfg_sel_end),
    .cfg_recover(cfg_recover),
    .cfg_hold   (cfg_hold),
    .cfg_cycle  (cfg_cycle),
    .setup_len  (setup_len),
    .pulse_len  (pulse_len),
    .post_len   (post_len),
    .hold_len   (hold_len),
    .cycle_min  (cycle_min)
  );

  psram_wr_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .req_data (req_data),
    .req_be   (req_be),
    .setup_len(setup_len),
    .pulse_len(pulse_len),
    .post_len (post_len),
    .cycle_min(cycle_min),
    .state    (state),
    .phase    (phase),
    .addr_q   (addr_q),
    .data_q   (data_q),
    .be_q     (be_q),
    .done     (wr_done)
  );

  psram_wr_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) pins_i (
    .state       (state),
    .phase       (phase),
    .hold_len    (hold_len),
    .addr_q      (addr_q),
    .data_q      (data_q),
    .be_q        (be_q),
    .ram_addr    (ram_addr),
    .ram_dq_out  (ram_dq_out),
    .ram_dq_oe   (ram_dq_oe),
    .ram_sel_n   (ram_sel_n),
    .ram_wr_n    (ram_wr_n),
    .ram_rd_n    (ram_rd_n),
    .ram_lane_n  (ram_lane_n),
    .ram_strobe_n(ram_strobe_n),
    .ram_cfg_sel (ram_cfg_sel)
  );

endmodule

// File: rtl/psram_wr_seq_chk.sv
module psram_wr_seq_chk #(
  parameter int ADDR_W = 22,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wr_done,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_dq_oe,
  input logic              ram_sel_n,
  input logic              ram_wr_n,
  input logic [LANES-1:0]  ram_lane_n
);

  // R3: after an accepted request the sequencer is busy
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R6: a write is only in effect with select and a lane low
  a_r6_write_has_lane: assert property (@(posedge clk) disable iff (rst)
    !ram_wr_n |-> (!ram_sel_n && (ram_lane_n != {LANES{1'b1}})));

  // R7: write enable rises while select is still low
  a_r7_wr_rises_first: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_wr_n) |-> !ram_sel_n);

  // R8: data is driven throughout the write pulse
  a_r8_data_in_pulse: assert property (@(posedge clk) disable iff (rst)
    !ram_wr_n |-> ram_dq_oe);

  // R9: address does not move in the cycle after select was low
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !ram_sel_n |=> $stable(ram_addr));

  // R10: done is a single-cycle pulse that coincides with ready
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wr_done);
  a_r10_done_ready: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> req_ready);

endmodule

bind psram_wr_seq psram_wr_seq_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wr_done   (wr_done),
  .ram_addr  (ram_addr),
  .ram_dq_oe (ram_dq_oe),
  .ram_sel_n (ram_sel_n),
  .ram_wr_n  (ram_wr_n),
  .ram_lane_n(ram_lane_n)
);

// File: tb/psram_wr_seq_tb_top.sv
module psram_wr_seq_tb_top;

  localparam int CW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst;
  logic [CW-1:0] c_setup, c_pulse, c_sel_end, c_recover, c_hold, c_cycle;
  logic          req_valid, req_ready;
  logic [21:0]   req_addr;
  logic [15:0]   req_data;
  logic [1:0]    req_be;
  logic          wr_done;
  logic [21:0]   ram_addr;
  logic [15:0]   ram_dq_out;
  logic          ram_dq_oe, ram_sel_n, ram_wr_n, ram_rd_n, ram_strobe_n, ram_cfg_sel;
  logic [1:0]    ram_lane_n;

  psram_wr_seq dut_i (
    .clk(clk), .rst(rst),
    .cfg_setup(c_setup), .cfg_pulse(c_pulse), .cfg_sel_end(c_sel_end),
    .cfg_recover(c_recover), .cfg_hold(c_hold), .cfg_cycle(c_cycle),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_be(req_be), .wr_done(wr_done),
    .ram_addr(ram_addr), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_sel_n(ram_sel_n), .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n),
    .ram_lane_n(ram_lane_n), .ram_strobe_n(ram_strobe_n), .ram_cfg_sel(ram_cfg_sel)
  );

  int n_run  = 0;
  int n_fail = 0;
  int m_setup, m_pulse, m_sel_end, m_recover, m_hold, m_cycle;  // model counts

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic idle_pins(string tag);
    check(tag, "sel_n idle", ram_sel_n, 1);
    check(tag, "wr_n idle", ram_wr_n, 1);
    check(tag, "lane_n idle", ram_lane_n, 2'b11);
    check(tag, "dq_oe idle", ram_dq_oe, 0);
    check(tag, "done idle", wr_done, 0);
    check(tag, "ready idle", req_ready, 1);
  endtask

  task automatic do_reset(int s, int p, int ce, int r, int h, int c);
    c_setup = CW'(s); c_pulse = CW'(p); c_sel_end = CW'(ce);
    c_recover = CW'(r); c_hold = CW'(h); c_cycle = CW'(c);
    m_setup = s; m_pulse = p; m_sel_end = ce; m_recover = r; m_hold = h; m_cycle = c;
    req_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    idle_pins("R1");
    rst = 1'b0;
    @(negedge clk);
    idle_pins("R1");
  endtask

  // One write; called at a negedge with the sequencer idle
  task automatic run_txn(logic [21:0] addr, logic [15:0] data, logic [1:0] be, string ovr);
    int s, p, a, l;
    logic act_w;
    s = (m_setup == 0) ? 1 : m_setup;
    p = imax(m_pulse, (m_sel_end > s) ? (m_sel_end - s) : 0);
    if (p == 0) p = 1;
    a = imax(m_recover, m_hold);
    if (a == 0) a = 1;
    l = imax(s + p + a, m_cycle);
    act_w = (be != 2'b00);
    req_valid = 1'b1; req_addr = addr; req_data = data; req_be = be;
    check("R3", "ready before accept", req_ready, 1);
    @(posedge clk);
    for (int k = 1; k <= l + 1; k++) begin
      bit in_setup, in_pulse, in_post, exp_sel, exp_oe;
      int j;
      string tag;
      logic [1:0] exp_lane;
      @(negedge clk);
      in_setup = (k <= s);
      in_pulse = (k > s) && (k <= s + p);
      in_post  = (k > s + p) && (k <= s + p + a);
      j = k - s - p - 1;
      tag = !act_w ? "R6" : in_setup ? "R4" : in_pulse ? "R5" : in_post ? "R7" : "R10";
      if (ovr != "") tag = ovr;
      exp_sel  = act_w && (in_setup || in_pulse || (in_post && j == 0));
      exp_lane = exp_sel ? ~be : 2'b11;
      exp_oe   = act_w && (in_pulse || (in_post && j < m_hold));
      check(tag, "sel_n", ram_sel_n, !exp_sel);
      check(tag, "wr_n", ram_wr_n, !(act_w && in_pulse));
      check((ovr != "") ? ovr : "R6", "lane_n", ram_lane_n, exp_lane);
      check((ovr != "") ? ovr : "R8", "dq_oe", ram_dq_oe, exp_oe);
      if (exp_oe) check("R8", "dq data", ram_dq_out, data);
      check("R9", "address", ram_addr, addr);
      check("R10", "ready", req_ready, (k == l + 1));
      check("R10", "done", wr_done, (k == l + 1));
      check("R2", "fixed pins", {ram_rd_n, ram_strobe_n, ram_cfg_sel}, 3'b100);
      if (k <= l) begin
        // R3: scramble the request while busy
        req_addr = 22'($urandom); req_data = 16'($urandom); req_be = 2'($urandom);
      end else begin
        req_valid = 1'b0;
      end
    end
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd7741);
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_data = '0; req_be = '0;

    // All counts zero: minimum lengths
    do_reset(0, 0, 0, 0, 0, 0);
    run_txn(22'h3FFFFF, 16'hA55A, 2'b11, "");
    run_txn(22'h000000, 16'h1234, 2'b01, "");

    // Chip-select-to-end stretches the pulse; hold beats recovery
    do_reset(3, 2, 8, 1, 3, 4);
    run_txn(22'h12345, 16'hBEEF, 2'b11, "");
    run_txn(22'h2AAAA, 16'h0F0F, 2'b10, "");
    run_txn(22'h15555, 16'hF00D, 2'b01, "");
    run_txn(22'h00F00, 16'hCAFE, 2'b00, "");
    // R11: new configuration after reset is ignored
    c_setup = 8'd9; c_pulse = 8'd9; c_sel_end = 8'd0;
    c_recover = 8'd9; c_hold = 8'd0; c_cycle = 8'd40;
    run_txn(22'h0ABCD, 16'h7777, 2'b11, "R11");

    // Minimum cycle forces padding
    do_reset(1, 1, 0, 2, 0, 20);
    run_txn(22'h1F0F0, 16'h8001, 2'b11, "");
    run_txn(22'h00001, 16'h4002, 2'b00, "");

    // Recovery longer than hold, zero hold
    do_reset(2, 3, 0, 4, 0, 0);
    run_txn(22'h20000, 16'h5A5A, 2'b10, "");

    // Random count sets and requests
    for (int c = 0; c < 6; c++) begin
      do_reset($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 12),
               $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 40));
      for (int t = 0; t < 6; t++)
        run_txn(22'($urandom), 16'($urandom), 2'($urandom), "");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule